// File: doc/BRIEF.md
# Smart Card Character Convention Detector and Decoder

This block sits behind the receive shift register of a smart card interface. Each received character arrives already deserialised as nine raw bits with a one-cycle valid strobe. The eight data bits are held in line order, with bit 0 as the first bit after the start bit, and bit 8 is the parity bit. The block turns every character into a byte in the direct convention and flags a parity error against a static even or odd parity setting.

After reset, and again each time software re-arms it, the block is in initial-character mode. In that mode it inspects the next character. If the character is one of the two legal opening characters, the block latches the convention flag, leaves the mode and emits that character decoded under the newly latched convention. If the character is anything else, the block raises a one-cycle invalid-initial pulse, emits no byte and stays in the mode. Outside the mode, every character is decoded with the latched convention. In the inverse convention the block reverses the bit order and inverts the data and parity bits.

Top module: `convDetect`

## Requirements
- R1: While reset is held, and in the cycle after it is released, initMode is 1 and inverseConv, outValid and badInitial are 0.
- R2: In initial-character mode, raw data 0x3B (line bits 1,1,0,1,1,1,0,0 from bit 0 upward) clears inverseConv and leaves the mode. In the next cycle it emits outByte 0x3B with outValid high.
- R3: In initial-character mode, raw data 0x03 (line bits 1,1,0,0,0,0,0,0) sets inverseConv and leaves the mode. In the next cycle it emits outByte 0x3F.
- R4: In initial-character mode, any other raw data gives badInitial high for exactly the next cycle. It gives no outValid and leaves both initMode and inverseConv unchanged.
- R5: Outside the mode with inverseConv 0, outByte equals rawChar[7:0], with outValid one cycle after rawValid.
- R6: Outside the mode with inverseConv 1, outByte bit 7-i equals the inverse of rawChar bit i.
- R7: The effective parity is rawChar[8] in the direct convention and its inverse in the inverse convention. With parityOdd 0, outParityErr is 1 when the decoded byte plus the effective parity holds an odd number of ones. With parityOdd 1, it is 1 when that count is even.
- R8: A pulse on armInit sets initMode from the next cycle. A pulse on clrInit clears it. armInit wins over clrInit and over an exit caused by a valid initial character in the same cycle.
- R9: A character arriving in the same cycle as armInit or clrInit is judged by the mode that was in effect before that clock edge.
- R10: outValid and badInitial are each high for at most one cycle per rawValid pulse, are never high together, and stay low when rawValid was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rawValid | input | 1 | One-cycle strobe for rawChar |
| rawChar | input | 9 | Raw character: bits 7..0 are data in line order (bit 0 first), bit 8 is parity |
| parityOdd | input | 1 | Static parity select: 0 even, 1 odd |
| armInit | input | 1 | Pulse that enters initial-character mode |
| clrInit | input | 1 | Pulse that leaves initial-character mode |
| outValid | output | 1 | Decoded byte valid, one cycle |
| outByte | output | 8 | Decoded direct-convention byte |
| outParityErr | output | 1 | Parity error for outByte |
| badInitial | output | 1 | One-cycle pulse for an unrecognised initial character |
| initMode | output | 1 | Initial-character mode active |
| inverseConv | output | 1 | Latched convention: 1 inverse, 0 direct |

## Verification
Software mode control and character arrival can land in the same cycle. The bench pairs armInit and clrInit with recognised characters, unrecognised characters and ordinary characters. It also drives armInit and clrInit together. A behavioural model applies the "old mode judges the character, arm wins" rule and is compared with the design every clock. Directed checks then confirm that the mode, the convention and the emitted byte settle where R8 and R9 require.

// File: rtl/convDetectPkg.sv
package convDetectPkg;
  localparam int CHAR_W = 8;
  localparam logic [CHAR_W-1:0] DIRECT_OPEN_RAW  = 8'h3B;
  localparam logic [CHAR_W-1:0] INVERSE_OPEN_RAW = 8'h03;

  typedef struct packed {
    logic emit;
    logic useInverse;
    logic flagBad;
  } ctrlStrobes_t;
endpackage

// File: rtl/convCtrl.sv
module convCtrl
  import convDetectPkg::*;
#(
  parameter int DATA_W = CHAR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rawValid,
  input  logic [DATA_W-1:0] rawData,
  input  logic              armInit,
  input  logic              clrInit,
  output logic              initMode,
  output logic              inverseConv,
  output ctrlStrobes_t      strobes
);
  localparam logic [DATA_W-1:0] DIRECT_PAT  = DATA_W'(DIRECT_OPEN_RAW);
  localparam logic [DATA_W-1:0] INVERSE_PAT = DATA_W'(INVERSE_OPEN_RAW);

  logic isDirect, isInverse, hitOpen;

  always_comb begin
    isDirect  = (rawData == DIRECT_PAT);
    isInverse = (rawData == INVERSE_PAT);
    hitOpen   = 1'b0;
    strobes   = '0;
    strobes.useInverse = inverseConv;
    if (rawValid) begin
      if (initMode) begin
        if (isDirect || isInverse) begin
          hitOpen            = 1'b1;
          strobes.emit       = 1'b1;
          strobes.useInverse = isInverse;
        end else begin
          strobes.flagBad = 1'b1;
        end
      end else begin
        strobes.emit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initMode    <= 1'b1;
      inverseConv <= 1'b0;
    end else begin
      if (hitOpen) inverseConv <= isInverse;
      if (armInit) initMode <= 1'b1;
      else if (clrInit || hitOpen) initMode <= 1'b0;
    end
  end

  // R8: arming always takes effect
  a_r8_arm_sets: assert property (@(posedge clk) disable iff (!rstN)
    armInit |=> initMode);
  // R8: clear without arm leaves the mode
  a_r8_clr_clears: assert property (@(posedge clk) disable iff (!rstN)
    (clrInit && !armInit) |=> !initMode);
  // R4: convention only moves on a character seen in initial-character mode
  a_r4_conv_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(initMode && rawValid) |=> $stable(inverseConv));
  // R3: inverse convention only rises from an opening character
  a_r3_inv_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inverseConv) |-> $past(initMode && rawValid && rawData == INVERSE_PAT));
endmodule

// File: rtl/convDatapath.sv
module convDatapath
  import convDetectPkg::*;
#(
  parameter int DATA_W = CHAR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] rawData,
  input  logic              rawParity,
  input  logic              parityOdd,
  output logic              outValid,
  output logic [DATA_W-1:0] outByte,
  output logic              outParityErr,
  output logic              badInitial
);
  logic [DATA_W-1:0] flipped, decoded;
  logic              effParity, parErr;

  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    assign flipped[DATA_W-1-i] = ~rawData[i];
  end

  always_comb begin
    decoded   = strobes.useInverse ? flipped : rawData;
    effParity = rawParity ^ strobes.useInverse;
    parErr    = (^{decoded, effParity}) ^ parityOdd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outByte      <= '0;
      outParityErr <= 1'b0;
      badInitial   <= 1'b0;
    end else begin
      outValid   <= strobes.emit;
      badInitial <= strobes.flagBad;
      if (strobes.emit) begin
        outByte      <= decoded;
        outParityErr <= parErr;
      end
    end
  end

  // R10: an emitted byte and an invalid-initial pulse never coincide
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && badInitial));
  // R4: an invalid-initial pulse lasts one cycle unless a new strobe refreshed it
  a_r4_bad_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (badInitial && !strobes.flagBad) |=> !badInitial);
endmodule

// File: rtl/convDetect.sv
module convDetect
  import convDetectPkg::*;
#(
  parameter int DATA_W = CHAR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rawValid,
  input  logic [DATA_W:0]   rawChar,
  input  logic              parityOdd,
  input  logic              armInit,
  input  logic              clrInit,
  output logic              outValid,
  output logic [DATA_W-1:0] outByte,
  output logic              outParityErr,
  output logic              badInitial,
  output logic              initMode,
  output logic              inverseConv
);
  ctrlStrobes_t strobes;

  convCtrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .rawValid(rawValid), .rawData(rawChar[DATA_W-1:0]),
    .armInit(armInit), .clrInit(clrInit), .initMode(initMode),
    .inverseConv(inverseConv), .strobes(strobes)
  );

  convDatapath #(.DATA_W(DATA_W)) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rawData(rawChar[DATA_W-1:0]),
    .rawParity(rawChar[DATA_W]), .parityOdd(parityOdd), .outValid(outValid),
    .outByte(outByte), .outParityErr(outParityErr), .badInitial(badInitial)
  );

  // R10: no output without a character in the previous cycle
  a_r10_needs_raw: assert property (@(posedge clk) disable iff (!rstN)
    (outValid || badInitial) |-> $past(rawValid));
  // R2: leaving the mode without software involvement emits a byte
  a_r2_exit_emits: assert property (@(posedge clk) disable iff (!rstN)
    (initMode && rawValid && !armInit && !clrInit && !badInitial) ##1 !initMode |-> outValid);
endmodule

// File: tb/convDetect_tb_top.sv
module convDetect_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rawValid = 1'b0;
  logic [8:0] rawChar = '0;
  logic parityOdd = 1'b0;
  logic armInit = 1'b0;
  logic clrInit = 1'b0;
  logic outValid, outParityErr, badInitial, initMode, inverseConv;
  logic [7:0] outByte;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  convDetect dut_i (
    .clk(clk), .rstN(rstN), .rawValid(rawValid), .rawChar(rawChar),
    .parityOdd(parityOdd), .armInit(armInit), .clrInit(clrInit),
    .outValid(outValid), .outByte(outByte), .outParityErr(outParityErr),
    .badInitial(badInitial), .initMode(initMode), .inverseConv(inverseConv)
  );

  // behavioural reference model
  bit mMode = 1, mInv = 0, mValid = 0, mErr = 0, mBad = 0;
  bit [7:0] mByte = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 1; mInv = 0; mValid = 0; mErr = 0; mBad = 0; mByte = 0;
    end else begin
      bit emit, inv, leave;
      int ones;
      emit = 0; inv = mInv; leave = 0; mBad = 0;
      if (rawValid) begin
        if (mMode) begin
          if (rawChar[7:0] == 8'h3B) begin emit = 1; inv = 0; leave = 1; end
          else if (rawChar[7:0] == 8'h03) begin emit = 1; inv = 1; leave = 1; end
          else mBad = 1;
        end else emit = 1;
      end
      if (emit) begin
        for (int i = 0; i < 8; i++)
          mByte[i] = inv ? !rawChar[7-i] : rawChar[i];
        ones = 0;
        for (int i = 0; i < 8; i++) ones += mByte[i];
        ones += (rawChar[8] ^ inv);
        mErr = parityOdd ? (ones % 2 == 0) : (ones % 2 == 1);
      end
      mValid = emit;
      if (leave) mInv = inv;
      if (armInit) mMode = 1;
      else if (clrInit || leave) mMode = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h time=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    chk("R8 initMode", initMode, mMode);
    chk("R2/R3 inverseConv", inverseConv, mInv);
    chk("R10 outValid", outValid, mValid);
    chk("R4 badInitial", badInitial, mBad);
    if (mValid) begin
      chk("R5/R6 outByte", outByte, mByte);
      chk("R7 outParityErr", outParityErr, mErr);
    end
  end

  task automatic cyc(input logic v, input logic [8:0] c, input logic a = 0, input logic cl = 0);
    @(negedge clk);
    rawValid = v; rawChar = c; armInit = a; clrInit = cl;
  endtask

  task automatic idle();
    cyc(0, 9'h0);
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 initMode", initMode, 1); chk("R1 inverseConv", inverseConv, 0);
    chk("R1 outValid", outValid, 0); chk("R1 badInitial", badInitial, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 post-release initMode", initMode, 1);
    // R4: unrecognised opening character
    cyc(1, 9'h0FF); idle();
    chk("R4 bad pulse", badInitial, 1); chk("R4 no byte", outValid, 0);
    chk("R4 mode kept", initMode, 1);
    idle(); chk("R4 pulse ends", badInitial, 0);
    // R2: direct opening character
    cyc(1, 9'h13B); idle();
    chk("R2 byte", outByte, 8'h3B); chk("R2 valid", outValid, 1);
    chk("R2 conv", inverseConv, 0); chk("R2 exit", initMode, 0);
    // R5/R7: direct data under both parity modes
    for (int p = 0; p < 2; p++) begin
      parityOdd = p[0];
      for (int k = 0; k < 20; k++) begin
        cyc(1, 9'($urandom)); if (k % 3 == 0) idle();
      end
    end
    idle();
    parityOdd = 0;
    // R9: arm together with a character while out of the mode
    cyc(1, 9'h0A5, 1, 0); idle();
    chk("R9 byte decoded outside mode", outValid, 1);
    chk("R9 byte value", outByte, 8'hA5); chk("R8 armed", initMode, 1);
    // R3: inverse opening character
    cyc(1, 9'h003); idle();
    chk("R3 byte", outByte, 8'h3F); chk("R3 conv", inverseConv, 1);
    chk("R3 exit", initMode, 0);
    // R6/R7: inverse data
    for (int p = 0; p < 2; p++) begin
      parityOdd = p[0];
      for (int k = 0; k < 20; k++) cyc(1, 9'($urandom));
    end
    idle();
    // R8: arm and clear together
    cyc(0, 9'h0, 1, 1); idle();
    chk("R8 arm wins over clear", initMode, 1);
    // R9: clear with a bad character while in mode
    cyc(1, 9'h155, 0, 1); idle();
    chk("R9 bad flagged", badInitial, 1); chk("R8 cleared", initMode, 0);
    chk("R9 conv kept", inverseConv, 1);
    // R8: arm with a valid opening character keeps the mode
    cyc(0, 9'h0, 1, 0);
    cyc(1, 9'h13B, 1, 0); idle();
    chk("R8 arm beats exit", initMode, 1); chk("R2 conv latched", inverseConv, 0);
    chk("R2 byte under arm", outByte, 8'h3B);
    cyc(1, 9'h003, 0, 0); idle();
    chk("R3 second exit", initMode, 0);
    repeat (3) idle();
    finished = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end
endmodule